// File: doc/BRIEF.md
# Prioritised Conversion Start Sequencer

This block decides which of sixteen conversion slots a single converter serves next. Each slot carries its own configuration: the input channel to sample, the external trigger line that starts it, the sampling window length, and an optional end-of-conversion interrupt line that re-arms it. A slot becomes pending when its selected trigger pulses, when software forces it through a multi-bit mask, or when its chosen interrupt line pulses. Pending requests wait until the converter is free.

A programmable boundary splits the slots into two groups. Slots below the boundary form a fixed-priority group in which the lowest number wins. Slots at or above it share service in round-robin order. The winner is handed to an external converter model as a one-cycle start pulse together with its slot number, channel and window. The block then holds a busy flag until the converter reports completion.

Top module: `conv_slot_sequencer`

## Requirements
- R1: After reset busy and conv_start are low, nothing is pending, and every slot holds channel 0, trigger select 0, interrupt source 0 and window field 15. With this configuration, pulses on trig_in and irq_line start no conversion.
- R2: A cfg_we cycle stores channel, trigger select, interrupt source and window field into slot cfg_slot. The window field is the sample length minus one, from 15 (16 cycles) to 511 (512 cycles); a written value below 15 is stored as 15. A grant presents the granted slot's stored channel on conv_chan and window field on conv_win.
- R3: Trigger select value s from 1 to 8 makes a pulse on trig_in[s-1] set the slot pending. Select 0 (software only) and values 9 to 15 ignore every trig_in line.
- R4: A force_we cycle makes every slot n with force_mask[n] = 1 pending, any number of bits at once, with one conversion per slot.
- R5: Interrupt source field 1 lets a pulse on irq_line[0] set the slot pending, field 2 lets irq_line[1] do so, and fields 0 and 3 ignore both lines.
- R6: A request for a slot that is already pending is absorbed and yields a single conversion. A request sampled on the same edge that grants the slot makes it pending again, so it is converted a second time.
- R7: With prio_mode = k, for k from 1 to 15, slots 0 to k-1 are a fixed-priority group. A pending slot in this group always wins over every other slot, and the lowest-numbered pending slot in the group wins.
- R8: Slots k to 15 are served in round robin. The search starts at a pointer that is 0 after reset, equals one past the last round-robin slot granted, and wraps from 15 to k. A pointer below k starts the search at k. prio_mode = 0 puts every slot in round robin.
- R9: prio_mode = 16 serves every slot in fixed order by slot number; values above 16 act as 16.
- R10: A request sampled on clock edge E produces conv_start high for one cycle after edge E+1 when the block is idle. busy rises with conv_start and stays high until the edge that samples conv_done high, after which it is low. No grant is made while busy is high.
- R11: Granting a slot clears its pending state, so a completed slot does not convert again without a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write enable for one slot's configuration |
| cfg_slot | input | 4 | Slot to configure |
| cfg_chan | input | 4 | Channel select to store |
| cfg_tsel | input | 4 | Trigger select to store (0 = software only, s = trig_in[s-1]) |
| cfg_win | input | 9 | Sample window length minus one |
| cfg_isrc | input | 2 | Interrupt line select (0 none, 1 line 0, 2 line 1, 3 none) |
| prio_mode | input | 5 | Fixed-priority boundary, 0 to 16 |
| force_we | input | 1 | Apply force_mask in this cycle |
| force_mask | input | 16 | Bit n forces slot n pending |
| trig_in | input | 8 | External trigger pulses |
| irq_line | input | 2 | End-of-conversion interrupt pulses fed back as triggers |
| conv_done | input | 1 | Converter reports completion |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_slot | output | 4 | Granted slot number |
| conv_chan | output | 4 | Channel of the granted slot |
| conv_win | output | 9 | Window field of the granted slot |
| busy | output | 1 | A conversion is in progress |

## Verification
A request sampled on edge E sets the slot pending at that edge, and the grant registers on E+1, so conv_start, conv_slot, conv_chan and conv_win are read one time unit after E+1. The bench's converter model raises conv_done two edges after it sees the start, so busy is expected high after the next two edges and low after the third, with the next grant one edge later. The checks take every output a moment after the edge that updates it. Grant order is logged by the converter model and compared with an order the bench computes from the pending mask, the boundary and its own copy of the round-robin pointer, over every priority mode and several masks.

// File: rtl/conv_seq_pkg.sv
// Shared encodings for the conversion start sequencer.
// Assumes: the interrupt source field is two bits wide.
package conv_seq_pkg;

    // Which end-of-conversion line re-arms a slot.
    typedef enum logic [1:0] {
        IRQ_SRC_NONE  = 2'd0,
        IRQ_SRC_LINE0 = 2'd1,
        IRQ_SRC_LINE1 = 2'd2,
        IRQ_SRC_RSVD  = 2'd3
    } irq_src_e;

endpackage

// File: rtl/conv_slot_cfg.sv
// Per-slot configuration storage: channel, trigger select, interrupt source
// and sample window field, one write port addressed by slot number.
// Assumes: writes arrive one slot per cycle; window fields below the floor
// are raised to the floor so the stored length never drops below the minimum.
module conv_slot_cfg #(
    parameter int N         = 16,
    parameter int CHAN_W    = 4,
    parameter int TSEL_W    = 4,
    parameter int WIN_W     = 9,
    parameter int MIN_FIELD = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [$clog2(N)-1:0]  cfg_slot,
    input  logic [CHAN_W-1:0]     cfg_chan,
    input  logic [TSEL_W-1:0]     cfg_tsel,
    input  logic [WIN_W-1:0]      cfg_win,
    input  logic [1:0]            cfg_isrc,
    output logic [CHAN_W-1:0]     chan_q [N],
    output logic [TSEL_W-1:0]     tsel_q [N],
    output logic [WIN_W-1:0]      win_q  [N],
    output logic [1:0]            isrc_q [N]
);
    localparam int SLOT_W = $clog2(N);
    localparam logic [WIN_W-1:0] WIN_FLOOR = WIN_W'(MIN_FIELD);

    logic [WIN_W-1:0] win_in;

    // Raise short window requests to the minimum legal field value.
    always_comb begin
        win_in = (cfg_win < WIN_FLOOR) ? WIN_FLOOR : cfg_win;
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Hold one slot's configuration, updated when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chan_q[g] <= '0;
                tsel_q[g] <= '0;
                win_q[g]  <= WIN_FLOOR;
                isrc_q[g] <= '0;
            end else if (cfg_we && (cfg_slot == SLOT_W'(g))) begin
                chan_q[g] <= cfg_chan;
                tsel_q[g] <= cfg_tsel;
                win_q[g]  <= win_in;
                isrc_q[g] <= cfg_isrc;
            end
        end

        p_win_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
            win_q[g] >= WIN_FLOOR);
    end

endmodule

// File: rtl/conv_req_collect.sv
// Gathers start requests per slot (external trigger, software force,
// interrupt feedback) into a pending vector and clears a slot on grant.
// Assumes: a request on the grant edge re-arms the slot (set beats clear).
module conv_req_collect
    import conv_seq_pkg::*;
#(
    parameter int N        = 16,
    parameter int NUM_TRIG = 8,
    parameter int TSEL_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TSEL_W-1:0]     tsel_q [N],
    input  logic [1:0]            isrc_q [N],
    input  logic [NUM_TRIG-1:0]   trig_in,
    input  logic [1:0]            irq_line,
    input  logic                  force_we,
    input  logic [N-1:0]          force_mask,
    input  logic                  gnt_vld,
    input  logic [$clog2(N)-1:0]  gnt_slot,
    output logic [N-1:0]          pend_q
);
    localparam int TEXT_W = 1 << TSEL_W;

    logic [TEXT_W-1:0] trig_ext;
    logic [N-1:0]      set_vec;
    logic [N-1:0]      clr_vec;

    // Put a constant zero at select 0 and zero-pad beyond the last line.
    assign trig_ext = TEXT_W'({trig_in, 1'b0});

    for (genvar g = 0; g < N; g++) begin : g_req
        logic irq_hit;

        // Decode the slot's interrupt source onto the two feedback lines.
        always_comb begin
            case (isrc_q[g])
                IRQ_SRC_LINE0: irq_hit = irq_line[0];
                IRQ_SRC_LINE1: irq_hit = irq_line[1];
                default:       irq_hit = 1'b0;
            endcase
        end

        // Combine all request sources for this slot.
        assign set_vec[g] = trig_ext[tsel_q[g]] | irq_hit | (force_we & force_mask[g]);
    end

    // Select the one slot being granted this cycle, if any.
    always_comb begin
        clr_vec = '0;
        if (gnt_vld) begin
            clr_vec[gnt_slot] = 1'b1;
        end
    end

    // Pending state: new requests merge, grants retire, repeats are absorbed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | set_vec;
        end
    end

    p_req_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

    p_grant_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && !set_vec[gnt_slot]) |=> !pend_q[$past(gnt_slot)]);

endmodule

// File: rtl/conv_slot_arbiter.sv
// Picks the next slot: lowest pending slot below the boundary first,
// otherwise the first pending slot at or after the round-robin pointer.
// Assumes: 'take' is asserted only in a cycle where pick_vld is high.
module conv_slot_arbiter #(
    parameter int N      = 16,
    parameter int MODE_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req,
    input  logic [MODE_W-1:0]     prio_mode,
    input  logic                  take,
    output logic                  pick_vld,
    output logic [$clog2(N)-1:0]  pick_slot
);
    localparam int SLOT_W = $clog2(N);
    localparam logic [MODE_W-1:0] ALL_FIXED = MODE_W'(N);

    logic [MODE_W-1:0] bound;
    logic [MODE_W-1:0] rr_start;
    logic [N-1:0]      fixed_req;
    logic [N-1:0]      rr_req;
    logic              fix_hit;
    logic [SLOT_W-1:0] fix_slot;
    logic              rr_hit;
    logic [SLOT_W-1:0] rr_slot;
    logic [SLOT_W-1:0] ptr_q;

    // Clamp the boundary to the number of slots.
    always_comb begin
        bound = (prio_mode > ALL_FIXED) ? ALL_FIXED : prio_mode;
    end

    // Split pending requests into the fixed and round-robin groups.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            fixed_req[i] = req[i] && (MODE_W'(i) < bound);
            rr_req[i]    = req[i] && !(MODE_W'(i) < bound);
        end
    end

    // Lowest-numbered pending slot of the fixed group.
    always_comb begin
        fix_hit  = 1'b0;
        fix_slot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fixed_req[i]) begin
                fix_hit  = 1'b1;
                fix_slot = SLOT_W'(i);
            end
        end
    end

    // Round-robin search origin, never below the boundary.
    always_comb begin
        rr_start = (MODE_W'(ptr_q) < bound) ? bound : MODE_W'(ptr_q);
    end

    // First pending round-robin slot, scanning upward from the origin.
    always_comb begin
        rr_hit  = 1'b0;
        rr_slot = '0;
        for (int i = 0; i < N; i++) begin
            if (!rr_hit && rr_req[(int'(rr_start) + i) % N]) begin
                rr_hit  = 1'b1;
                rr_slot = SLOT_W'((int'(rr_start) + i) % N);
            end
        end
    end

    assign pick_vld  = fix_hit | rr_hit;
    assign pick_slot = fix_hit ? fix_slot : rr_slot;

    // Advance the pointer past each round-robin grant, wrapping to the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take && !fix_hit && rr_hit) begin
            ptr_q <= (rr_slot == SLOT_W'(N - 1)) ? SLOT_W'(bound) : rr_slot + SLOT_W'(1);
        end
    end

    p_pick_is_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> req[pick_slot]);

    p_fixed_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_req != '0) |-> (MODE_W'(pick_slot) < bound));

    p_full_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bound == ALL_FIXED && req != '0) |-> (pick_slot == SLOT_W'($countones(req) == 0 ? 0 : pick_slot)) && fix_hit);

endmodule

// File: rtl/conv_slot_sequencer.sv
// Top of the conversion start sequencer: configuration store, request
// collection, arbitration and a single-conversion dispatch stage with busy.
// Assumes: conv_done is pulsed by the converter once per started conversion;
// prio_mode changes only while nothing is pending.
module conv_slot_sequencer #(
    parameter int N        = 16,
    parameter int NUM_TRIG = 8,
    parameter int CHAN_W   = 4,
    parameter int WIN_W    = 9,
    parameter int MIN_WIN  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [$clog2(N)-1:0]          cfg_slot,
    input  logic [CHAN_W-1:0]             cfg_chan,
    input  logic [$clog2(NUM_TRIG+1)-1:0] cfg_tsel,
    input  logic [WIN_W-1:0]              cfg_win,
    input  logic [1:0]                    cfg_isrc,
    input  logic [$clog2(N+1)-1:0]        prio_mode,
    input  logic                          force_we,
    input  logic [N-1:0]                  force_mask,
    input  logic [NUM_TRIG-1:0]           trig_in,
    input  logic [1:0]                    irq_line,
    input  logic                          conv_done,
    output logic                          conv_start,
    output logic [$clog2(N)-1:0]          conv_slot,
    output logic [CHAN_W-1:0]             conv_chan,
    output logic [WIN_W-1:0]              conv_win,
    output logic                          busy
);
    localparam int SLOT_W    = $clog2(N);
    localparam int TSEL_W    = $clog2(NUM_TRIG + 1);
    localparam int MODE_W    = $clog2(N + 1);
    localparam int MIN_FIELD = MIN_WIN - 1;

    logic [CHAN_W-1:0] slot_chan [N];
    logic [TSEL_W-1:0] slot_tsel [N];
    logic [WIN_W-1:0]  slot_win  [N];
    logic [1:0]        slot_isrc [N];
    logic [N-1:0]      pend;
    logic              pick_vld;
    logic [SLOT_W-1:0] pick_slot;
    logic              take;

    logic              busy_q;
    logic              start_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CHAN_W-1:0] chan_q;
    logic [WIN_W-1:0]  win_q;

    conv_slot_cfg #(
        .N(N), .CHAN_W(CHAN_W), .TSEL_W(TSEL_W), .WIN_W(WIN_W), .MIN_FIELD(MIN_FIELD)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_chan(cfg_chan),
        .cfg_tsel(cfg_tsel), .cfg_win(cfg_win), .cfg_isrc(cfg_isrc),
        .chan_q(slot_chan), .tsel_q(slot_tsel), .win_q(slot_win), .isrc_q(slot_isrc)
    );

    conv_req_collect #(
        .N(N), .NUM_TRIG(NUM_TRIG), .TSEL_W(TSEL_W)
    ) req_i (
        .clk(clk), .rst_n(rst_n),
        .tsel_q(slot_tsel), .isrc_q(slot_isrc),
        .trig_in(trig_in), .irq_line(irq_line),
        .force_we(force_we), .force_mask(force_mask),
        .gnt_vld(take), .gnt_slot(pick_slot),
        .pend_q(pend)
    );

    conv_slot_arbiter #(
        .N(N), .MODE_W(MODE_W)
    ) arb_i (
        .clk(clk), .rst_n(rst_n),
        .req(pend), .prio_mode(prio_mode), .take(take),
        .pick_vld(pick_vld), .pick_slot(pick_slot)
    );

    // A grant is taken only while the converter is idle.
    assign take = pick_vld && !busy_q;

    // Dispatch: latch the winner's settings, pulse start, hold busy until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            slot_q  <= '0;
            chan_q  <= '0;
            win_q   <= '0;
        end else begin
            start_q <= take;
            if (take) begin
                busy_q <= 1'b1;
                slot_q <= pick_slot;
                chan_q <= slot_chan[pick_slot];
                win_q  <= slot_win[pick_slot];
            end else if (busy_q && conv_done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign conv_start = start_q;
    assign conv_slot  = slot_q;
    assign conv_chan  = chan_q;
    assign conv_win   = win_q;
    assign busy       = busy_q;

    p_start_with_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> busy);

    p_busy_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> !busy);

endmodule

// File: tb/conv_slot_sequencer_tb.sv
// Bench for the conversion start sequencer: converter model with fixed
// completion delay, sweep of all priority modes, directed request tests.
module conv_slot_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_slot;
    logic [3:0]  cfg_chan;
    logic [3:0]  cfg_tsel;
    logic [8:0]  cfg_win;
    logic [1:0]  cfg_isrc;
    logic [4:0]  prio_mode;
    logic        force_we;
    logic [15:0] force_mask;
    logic [7:0]  trig_in;
    logic [1:0]  irq_line;
    logic        conv_done;
    logic        conv_start;
    logic [3:0]  conv_slot;
    logic [3:0]  conv_chan;
    logic [8:0]  conv_win;
    logic        busy;

    int nvec = 0;
    int nerr = 0;
    int lg_cnt = 0;
    int lg_slot [4096];
    int lg_chan [4096];
    int lg_win  [4096];

    always #(CLK_PERIOD / 2) clk = ~clk;

    conv_slot_sequencer dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_chan(cfg_chan),
        .cfg_tsel(cfg_tsel), .cfg_win(cfg_win), .cfg_isrc(cfg_isrc),
        .prio_mode(prio_mode), .force_we(force_we), .force_mask(force_mask),
        .trig_in(trig_in), .irq_line(irq_line), .conv_done(conv_done),
        .conv_start(conv_start), .conv_slot(conv_slot), .conv_chan(conv_chan),
        .conv_win(conv_win), .busy(busy)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Converter model: log each start, report done two edges later.
    initial begin
        conv_done = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (conv_start) begin
                lg_slot[lg_cnt] = int'(conv_slot);
                lg_chan[lg_cnt] = int'(conv_chan);
                lg_win[lg_cnt]  = int'(conv_win);
                lg_cnt++;
                repeat (2) @(posedge clk);
                #1 conv_done = 1'b1;
                @(posedge clk);
                #1 conv_done = 1'b0;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic cfg_write(input int s, input int ch, input int ts, input int w, input int is);
        cfg_we = 1'b1;
        cfg_slot = 4'(s);
        cfg_chan = 4'(ch);
        cfg_tsel = 4'(ts);
        cfg_win = 9'(w);
        cfg_isrc = 2'(is);
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic program_all();
        for (int s = 0; s < N; s++) cfg_write(s, 15 - s, 0, 15 + 31 * s, 0);
    endtask

    task automatic force_slots(input logic [15:0] m);
        force_mask = m;
        force_we = 1'b1;
        tick(1);
        force_we = 1'b0;
    endtask

    // Wait for a grant count, then allow time for any unexpected extra grant.
    task automatic wait_count(input int target, input string tag);
        int t;
        t = 0;
        while (lg_cnt < target && t < 3000) begin
            tick(1);
            t++;
        end
        tick(10);
        chk(lg_cnt == target, tag, lg_cnt, target);
    endtask

    // Expected winner from the pending mask, boundary and pointer.
    function automatic int ref_pick(input logic [15:0] p, input int k, input int ptr);
        int st;
        for (int i = 0; i < k; i++) if (p[i]) return i;
        st = (ptr < k) ? k : ptr;
        for (int i = 0; i < N; i++) begin
            if (((st + i) % N) >= k && p[(st + i) % N]) return (st + i) % N;
        end
        return -1;
    endfunction

    initial begin : main
        logic [15:0] masks [3];
        logic [15:0] p;
        int mode, k, ptr, base, n, s;
        int expv [32];
        string tg;

        masks[0] = 16'hFFFF;
        masks[1] = 16'h5A3C;
        masks[2] = 16'h8001;
        cfg_we = 0; cfg_slot = 0; cfg_chan = 0; cfg_tsel = 0; cfg_win = 0; cfg_isrc = 0;
        prio_mode = 5'd16; force_we = 0; force_mask = 0; trig_in = 0; irq_line = 0;

        // R1: reset state and reset configuration.
        do_reset();
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(conv_start == 1'b0, "R1 start after reset", int'(conv_start), 0);
        base = lg_cnt;
        trig_in = 8'hFF; irq_line = 2'b11;
        tick(1);
        trig_in = 0; irq_line = 0;
        wait_count(base, "R1 no grant from triggers with reset config");
        force_slots(16'h0001);
        wait_count(base + 1, "R1 forced grant count");
        chk(lg_win[base] == 15, "R1 reset window field", lg_win[base], 15);
        chk(lg_chan[base] == 0, "R1 reset channel", lg_chan[base], 0);

        // R7 R8 R9 R4 R2: sweep every priority mode with several masks.
        for (int mi = 0; mi < 18; mi++) begin
            mode = (mi == 17) ? 20 : mi;
            k = (mode > 16) ? 16 : mode;
            ptr = 0;
            do_reset();
            program_all();
            prio_mode = 5'(mode);
            tick(1);
            tg = (k == 0) ? "R8 round-robin order" : ((k == 16) ? "R9 fixed order" : "R7 mixed order");
            for (int b = 0; b < 3; b++) begin
                p = masks[b];
                base = lg_cnt;
                n = 0;
                while (p != 0) begin
                    s = ref_pick(p, k, ptr);
                    expv[n] = s;
                    n++;
                    p[s] = 1'b0;
                    if (s >= k) ptr = (s == 15) ? k : s + 1;
                end
                force_slots(masks[b]);
                wait_count(base + n, "R4 one grant per forced slot");
                for (int i = 0; i < n; i++) begin
                    chk(lg_slot[base + i] == expv[i], tg, lg_slot[base + i], expv[i]);
                    chk(lg_chan[base + i] == 15 - expv[i], "R2 channel", lg_chan[base + i], 15 - expv[i]);
                    chk(lg_win[base + i] == 15 + 31 * expv[i], "R2 window", lg_win[base + i], 15 + 31 * expv[i]);
                end
            end
        end

        // Directed tests in full fixed mode.
        do_reset();
        program_all();
        prio_mode = 5'd16;
        tick(1);

        // R2: short window raised to floor, maximum kept.
        cfg_write(3, 9, 0, 4, 0);
        cfg_write(4, 6, 0, 511, 0);
        base = lg_cnt;
        force_slots(16'h0018);
        wait_count(base + 2, "R2 grant count");
        chk(lg_win[base] == 15, "R2 window floor", lg_win[base], 15);
        chk(lg_win[base + 1] == 511, "R2 window maximum", lg_win[base + 1], 511);
        chk(lg_chan[base] == 9, "R2 written channel", lg_chan[base], 9);

        // R3 R10: trigger latency and busy span.
        cfg_write(2, 13, 3, 15 + 62, 0);
        trig_in = 8'h04;
        tick(1);
        trig_in = 8'h00;
        chk(conv_start == 1'b0, "R10 no start one edge after trigger", int'(conv_start), 0);
        tick(1);
        chk(conv_start == 1'b1, "R10 start two edges after trigger", int'(conv_start), 1);
        chk(conv_slot == 4'd2, "R3 triggered slot", int'(conv_slot), 2);
        chk(busy == 1'b1, "R10 busy with start", int'(busy), 1);
        tick(1);
        chk(conv_start == 1'b0, "R10 start lasts one cycle", int'(conv_start), 0);
        chk(busy == 1'b1, "R10 busy held", int'(busy), 1);
        tick(1);
        chk(busy == 1'b1, "R10 busy held until done", int'(busy), 1);
        tick(1);
        chk(busy == 1'b0, "R10 busy released after done", int'(busy), 0);
        tick(10);

        // R3: select 0 and out-of-range selects ignore triggers.
        cfg_write(6, 1, 12, 15, 0);
        base = lg_cnt;
        trig_in = 8'hFB;
        tick(1);
        trig_in = 0;
        wait_count(base, "R3 unselected triggers ignored");

        // R6: repeats absorbed while pending.
        base = lg_cnt;
        force_slots(16'h0001);
        trig_in = 8'h04;
        tick(3);
        trig_in = 0;
        wait_count(base + 2, "R6 repeated trigger gives one conversion");
        chk(lg_slot[base] == 0, "R6 first grant", lg_slot[base], 0);
        chk(lg_slot[base + 1] == 2, "R6 second grant", lg_slot[base + 1], 2);
        wait_count(base + 2, "R11 no conversion after pending cleared");

        // R6: request on the grant edge re-arms the slot.
        base = lg_cnt;
        trig_in = 8'h04;
        tick(2);
        trig_in = 0;
        wait_count(base + 2, "R6 grant-edge request converts again");
        chk(lg_slot[base + 1] == 2, "R6 re-armed slot", lg_slot[base + 1], 2);

        // R5: interrupt feedback sources.
        cfg_write(7, 7, 0, 15, 2);
        cfg_write(9, 5, 0, 15, 1);
        cfg_write(11, 3, 0, 15, 3);
        base = lg_cnt;
        irq_line = 2'b01;
        tick(1);
        irq_line = 0;
        wait_count(base + 1, "R5 line 0 count");
        chk(lg_slot[base] == 9, "R5 line 0 slot", lg_slot[base], 9);
        base = lg_cnt;
        irq_line = 2'b10;
        tick(1);
        irq_line = 0;
        wait_count(base + 1, "R5 line 1 count");
        chk(lg_slot[base] == 7, "R5 line 1 slot", lg_slot[base], 7);
        base = lg_cnt;
        irq_line = 2'b11;
        tick(1);
        irq_line = 0;
        wait_count(base + 2, "R5 both lines, source 3 ignored");
        chk(lg_slot[base] == 7, "R5 both lines first", lg_slot[base], 7);
        chk(lg_slot[base + 1] == 9, "R5 both lines second", lg_slot[base + 1], 9);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule